// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-pin general-purpose I/O port on a simple memory-mapped bus with byte-wide data. It holds a direction register and an output data register, and it drives three pad vectors: the output value, the output enable and the sampled input. Each pin's pad input passes through a two-flop synchroniser before software can read it.

Data accesses use the address as a per-pin mask. Address bit (n+2) selects pin n. A write therefore changes only the selected pins, and a read returns zero on every pin that is not selected. Software can set, clear or sample any group of pins in one bus access, with no read-modify-write sequence.

Software can load a pin's output value while the pin is still an input. The pin then drives that level from the first cycle it becomes an output.

Top module: `gpio_mask_port`

## Requirements
- R1: While reset is held and right after it is released, every pin is an input (`pad_oe` = 0x00), `pad_out` = 0x00 and `bus_rdata` = 0x00.
- R2: The direction register sits at byte offset 0x400. A 1 in bit n makes pin n an output. A write at that offset loads all eight bits, `pad_oe` follows the register, and a read at that offset returns it.
- R3: Every offset below 0x400 is a data access. Address bit (n+2) enables pin n, so a single pin sits at offset 1 << (n+2). Address bits 1:0 are ignored.
- R4: A data write loads `bus_wdata` bit n into output bit n only for pins whose mask bit is 1. Every other output bit keeps its value. `pad_out` equals the output register.
- R5: A data read returns 0 in every bit position whose mask bit is 0.
- R6: A data read of a selected pin that is an output returns the value that pin is driving.
- R7: A data read of a selected pin that is an input returns `pad_in` through two flops. A change of `pad_in` that occurs between edges is not yet seen by reads presented at the next two rising edges. It is seen by a read presented at the third rising edge.
- R8: Output values can be written while pins are inputs. `pad_out` shows them whatever the direction, so a pin drives the loaded level as soon as its direction bit is set.
- R9: Offsets above 0x400 are unmapped. Reads there return 0x00, and writes there change neither register.
- R10: Read data is registered. `bus_rdata` carries the result in the cycle after a rising edge at which `bus_rd` was high, and is 0x00 after any edge at which `bus_rd` was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Asynchronous pad inputs |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 = drive |

## Verification
The bound checker tests these rules on every cycle:
- A data write changes only the selected output bits and loads `bus_wdata` into the selected ones.
- A data read never returns a 1 on a pin that is not selected, and a selected output pin reads back its driven value.
- A direction write appears on `pad_oe` at once.
- A write to an unmapped offset leaves both pad vectors unchanged.
- `bus_rdata` is zero after any edge without a read.

Only the directed scenarios show the synchroniser latency of input pins and the direction register read-back. The same holds for output preload before a direction change, for pins of mixed direction read together, and for address bits 1:0 being ignored.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

    // Which register an access falls into.
    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_DATA = 2'd1,
        RGN_DIR  = 2'd2
    } gpio_region_e;

endpackage

// File: rtl/gpio_mask_decode.sv
module gpio_mask_decode
    import gpio_mask_pkg::*;
#(
    parameter int unsigned PINS   = 8,
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output gpio_region_e      region,
    output logic [PINS-1:0]   pin_mask
);

    // The direction register sits right above the data window.
    localparam logic [ADDR_W-1:0] DIR_OFS = ADDR_W'(1) << (PINS + 2);

    always_comb begin
        pin_mask = addr[PINS+1:2];
        if (addr < DIR_OFS) begin
            region = RGN_DATA;
        end else if (addr == DIR_OFS) begin
            region = RGN_DIR;
        end else begin
            region = RGN_NONE;
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
    import gpio_mask_pkg::*;
#(
    parameter int unsigned PINS        = 8,
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe
);

    typedef struct packed {
        logic [PINS-1:0] dir;
        logic [PINS-1:0] dout;
        logic [PINS-1:0] rdata;
    } port_state_t;

    port_state_t     st_d, st_q;
    gpio_region_e    region;
    logic [PINS-1:0] pin_mask;
    logic [PINS-1:0] in_sync;
    logic [PINS-1:0] pin_val;

    gpio_mask_decode #(
        .PINS   (PINS),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .addr     (bus_addr),
        .region   (region),
        .pin_mask (pin_mask)
    );

    gpio_in_sync #(
        .WIDTH  (PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (in_sync)
    );

    // Next-state logic.
    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        // Output pins read their driven level, input pins read the synchronised pad.
        pin_val    = (st_q.dir & st_q.dout) | (~st_q.dir & in_sync);

        if (bus_wr) begin
            unique case (region)
                RGN_DATA: st_d.dout = (st_q.dout & ~pin_mask) | (bus_wdata & pin_mask);
                RGN_DIR:  st_d.dir  = bus_wdata;
                default:  ;
            endcase
        end

        if (bus_rd) begin
            unique case (region)
                RGN_DATA: st_d.rdata = pin_val & pin_mask;
                RGN_DIR:  st_d.rdata = st_q.dir;
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign pad_out   = st_q.dout;
    assign pad_oe    = st_q.dir;

endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
    parameter int unsigned PINS   = 8,
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [PINS-1:0]   bus_wdata,
    input logic [PINS-1:0]   bus_rdata,
    input logic [PINS-1:0]   pad_out,
    input logic [PINS-1:0]   pad_oe
);

    localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(1) << (PINS + 2);

    logic            in_data, at_dir, off_map;
    logic [PINS-1:0] sel;

    assign in_data = bus_addr < DIR_ADDR;
    assign at_dir  = bus_addr == DIR_ADDR;
    assign off_map = bus_addr > DIR_ADDR;
    assign sel     = bus_addr[PINS+1:2];

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0 && bus_rdata == '0));

    // R2
    a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_dir) |=> pad_oe == $past(bus_wdata));

    // R4
    a_r4_keep_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && in_data) |=> (pad_out & ~$past(sel)) == ($past(pad_out) & ~$past(sel)));

    // R4
    a_r4_load_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && in_data) |=> (pad_out & $past(sel)) == ($past(bus_wdata) & $past(sel)));

    // R5
    a_r5_read_unselected_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && in_data) |=> (bus_rdata & ~$past(sel)) == '0);

    // R6
    a_r6_output_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && in_data) |=>
            (bus_rdata & $past(sel & pad_oe)) == $past(pad_out & sel & pad_oe));

    // R9
    a_r9_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && off_map) |=> ($stable(pad_out) && $stable(pad_oe)));

    // R9
    a_r9_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && off_map) |=> bus_rdata == '0);

    // R10
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == '0);

endmodule

bind gpio_mask_port gpio_mask_port_chk #(
    .PINS   (PINS),
    .ADDR_W (ADDR_W)
) u_chk (.*);

// File: tb/tb_gpio_mask_port.sv
`timescale 1ns/1ps
module tb_gpio_mask_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out;
    logic [7:0]  pad_oe;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    localparam logic [11:0] DIR_OFS = 12'h400;

    always #2.5 clk = ~clk;

    gpio_mask_port dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        d        = bus_rdata;
        bus_rd   = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] r;
        check("R1", "pad_oe after reset", pad_oe, 8'h00);
        check("R1", "pad_out after reset", pad_out, 8'h00);
        check("R1", "rdata after reset", bus_rdata, 8'h00);
        bus_read(DIR_OFS, r);
        check("R1", "direction read after reset", r, 8'h00);
    endtask

    task automatic t_direction();
        logic [7:0] r;
        bus_write(DIR_OFS, 8'hA5);
        check("R2", "pad_oe follows direction write", pad_oe, 8'hA5);
        bus_read(DIR_OFS, r);
        check("R2", "direction read back", r, 8'hA5);
    endtask

    task automatic t_masked_write();
        bus_write(DIR_OFS, 8'hFF);
        bus_write(12'h3FC, 8'h5A);
        check("R4", "all-pin write", pad_out, 8'h5A);
        bus_write(12'h03C, 8'hA5);
        check("R4", "low nibble masked write", pad_out, 8'h55);
        bus_write(12'h100, 8'h00);
        check("R3", "single pin 6 clear", pad_out, 8'h15);
        bus_write(12'h101, 8'h40);
        check("R3", "address bits 1:0 ignored", pad_out, 8'h55);
        bus_write(12'h000, 8'hFF);
        check("R4", "empty mask changes nothing", pad_out, 8'h55);
    endtask

    task automatic t_masked_read();
        logic [7:0] r;
        bus_read(12'h3C0, r);
        check("R5", "upper nibble masked read", r, 8'h50);
        bus_read(12'h000, r);
        check("R5", "empty mask read", r, 8'h00);
        bus_read(12'h3FC, r);
        check("R6", "output pins read driven value", r, 8'h55);
        @(negedge clk);
        check("R10", "rdata idle after read", bus_rdata, 8'h00);
    endtask

    task automatic t_input_sync();
        bus_write(DIR_OFS, 8'h00);
        pad_in = 8'h00;
        repeat (4) @(negedge clk);
        pad_in   = 8'h3C;
        bus_addr = 12'h3FC;
        bus_rd   = 1'b1;
        @(negedge clk);
        check("R7", "input change hidden at first edge", bus_rdata, 8'h00);
        @(negedge clk);
        check("R7", "input change hidden at second edge", bus_rdata, 8'h00);
        @(negedge clk);
        check("R7", "input change seen at third edge", bus_rdata, 8'h3C);
        bus_rd = 1'b0;
    endtask

    task automatic t_mixed();
        logic [7:0] r;
        bus_write(DIR_OFS, 8'h0F);
        bus_write(12'h3FC, 8'hFF);
        pad_in = 8'h5A;
        repeat (3) @(negedge clk);
        bus_read(12'h3FC, r);
        check("R6", "mixed direction read", r, 8'h5F);
        bus_read(12'h0C0, r);
        check("R7", "masked input pins read", r, 8'h10);
        check("R8", "pad_out independent of direction", pad_out, 8'hFF);
    endtask

    task automatic t_preload();
        bus_write(DIR_OFS, 8'h00);
        bus_write(12'h3FC, 8'h00);
        bus_write(12'h010, 8'h04);
        check("R8", "preload while input", pad_out, 8'h04);
        check("R8", "still input after preload", pad_oe, 8'h00);
        bus_write(DIR_OFS, 8'h04);
        check("R8", "pin 2 enabled", pad_oe, 8'h04);
        check("R8", "pin 2 drives loaded level", pad_out, 8'h04);
    endtask

    task automatic t_unmapped();
        logic [7:0] r;
        bus_write(12'h404, 8'hFF);
        bus_write(12'h800, 8'hFF);
        check("R9", "unmapped write leaves pad_oe", pad_oe, 8'h04);
        check("R9", "unmapped write leaves pad_out", pad_out, 8'h04);
        bus_read(12'h404, r);
        check("R9", "unmapped read 0x404", r, 8'h00);
        bus_read(12'hFFC, r);
        check("R9", "unmapped read 0xFFC", r, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direction();
        t_masked_write();
        t_masked_read();
        t_input_sync();
        t_mixed();
        t_preload();
        t_unmapped();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL R10 watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule